// File: doc/BRIEF.md
# PoE port detection sequencer

This block runs the signature-detection phase of one Power-over-Ethernet port. A detect command starts an attempt. The block keeps the power-switch enable low for the whole phase and selects a low probe level, then a high one. At each level it first waits for the front end to settle. It then accumulates the digitized current and voltage samples over an integration window, which is long enough that 50 Hz and 60 Hz mains pickup averages out. From the two mean points it derives a slope resistance, (V2 - V1) * RES_SCALE / (I2 - I1). It classifies the attached load into one of seven outcomes and reports that outcome with a one-cycle done pulse.

All timing counts a 1 ms tick input, so the settle time, the integration window and the retry wait are numbers of ticks. The midspan mode and the large-capacitance enable are captured when the command is accepted. In midspan mode a failed attempt is followed by a backoff wait, and then a new attempt starts by itself. A valid signature ends the retrying, and any new command cancels the pending wait. The analog front end, classification and power-up are outside this block.

The state machine has seven states. ST_IDLE waits for a command. ST_SETTLE1 and ST_INTEG1 handle the low level, and ST_SETTLE2 and ST_INTEG2 handle the high level. ST_VERDICT lasts one cycle and classifies the load. ST_BACKOFF is the midspan wait.

The transitions are as follows. A command moves any state to ST_SETTLE1. The timer expiry advances ST_SETTLE1 to ST_INTEG1, ST_INTEG1 to ST_SETTLE2, ST_SETTLE2 to ST_INTEG2, and ST_INTEG2 to ST_VERDICT. From ST_VERDICT the machine goes to ST_BACKOFF when the verdict is a failure in midspan mode, and to ST_IDLE otherwise. The timer expiry moves ST_BACKOFF to ST_SETTLE1.

Top module: `poe_detect_seq`

## Requirements
- R1: gate_en is 0 in every cycle, including the whole detection phase.
- R2: After a command, probe_sel is 0 for SETTLE_MS ticks of settling and then for INTEG_MS ticks of integration. probe_sel is then 1 for another SETTLE_MS plus INTEG_MS ticks. A timer phase ends in the cycle of its last tick. SETTLE_MS must be at least 2, so the two test points are at least 2 ms apart.
- R3: The mean current and mean voltage of each point are the signed sums of the samples taken with smp_vld=1 during that point's integration state, divided by their count and truncated toward zero. Samples taken at any other time, or with smp_vld=0, have no effect.
- R4: The 3-bit det_result codes are: 0 valid, 1 open circuit, 2 low resistance, 3 high resistance, 4 high capacitance, 5 positive DC supply, 6 negative DC supply, 7 no result. The value after reset is 7.
- R5: If both mean voltages are >= V_POS_TH, the result is 5. If both are <= V_NEG_TH, the result is 6. This check comes before all the others.
- R6: If either point's drift is larger than the drift limit, the result is 4. A point's drift is |last voltage sample - first voltage sample| over its integration window. The limit is DRIFT_LARGE when big_cap_en was 1 at the command, and DRIFT_NORM otherwise. This check comes after R5 and before R7 and R8.
- R7: If |I2 - I1| <= I_MIN_DIFF, the result is 1 (open circuit).
- R8: The slope resistance R = (V2 - V1) * RES_SCALE / (I2 - I1) is truncated toward zero. R < R_ACC_LO gives 2, R > R_ACC_HI gives 3, and any other value gives 0.
- R9: det_done pulses for one cycle. The pulse comes two cycles after the cycle of the last tick of the second integration window. det_result changes only together with det_done and holds its value between pulses.
- R10: Without midspan, every verdict returns the block to idle. With midspan, a failed verdict (code other than 0) waits BACKOFF_MS ticks and then starts a new attempt at settling. A valid verdict ends the retrying. The first attempt starts in the cycle after the command.
- R11: A command in any state restarts the attempt at the first settle. It clears both points and captures midspan_en and big_cap_en. A command during backoff cancels the wait. A command in the verdict cycle still lets that verdict be reported.
- R12: In idle, ms_tick and samples have no effect. No det_done occurs and det_result keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| det_cmd | input | 1 | Detect command strobe |
| midspan_en | input | 1 | Retry-with-backoff mode, captured at the command |
| big_cap_en | input | 1 | Raises the capacitance drift limit, captured at the command |
| smp_vld | input | 1 | Sample valid |
| smp_i | input | DW | Signed current sample |
| smp_v | input | DW | Signed voltage sample |
| probe_sel | output | 1 | Probe level select: 0 low point, 1 high point |
| gate_en | output | 1 | Power switch enable, held low |
| det_done | output | 1 | One-cycle verdict pulse |
| det_result | output | 3 | Verdict code (R4) |

## Verification
Two events can fall in the same cycle. A new command can arrive in the very cycle the verdict is formed, which makes the report and the restart coincide. A command can also arrive while the backoff wait is running, which makes the cancel and the retry timer compete. The bench provokes the first case by watching its own reference model and driving the command exactly when the model enters the verdict state. It then checks that two completion pulses appear and that the probe sequence restarts. It provokes the second case by commanding a valid load during a midspan backoff. There it checks that the verdict arrives within one normal attempt length, with no backoff wait added. A cycle-by-cycle comparison of every output against the behavioural model judges both cases.

// File: rtl/poe_det_pkg.sv
package poe_det_pkg;

    typedef enum logic [2:0] {
        RES_VALID  = 3'd0,
        RES_OPEN   = 3'd1,
        RES_LOW_R  = 3'd2,
        RES_HIGH_R = 3'd3,
        RES_HIGH_C = 3'd4,
        RES_DC_POS = 3'd5,
        RES_DC_NEG = 3'd6,
        RES_NONE   = 3'd7
    } det_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE1,
        ST_INTEG1,
        ST_SETTLE2,
        ST_INTEG2,
        ST_VERDICT,
        ST_BACKOFF
    } det_st_e;

endpackage

// File: rtl/poe_det_timer.sv
module poe_det_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;

    assign expire = run && tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run || expire)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R2
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));

endmodule

// File: rtl/poe_det_accum.sv
module poe_det_accum #(
    parameter int DW = 16,
    parameter int NW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 vld,
    input  logic signed [DW-1:0] smp_i,
    input  logic signed [DW-1:0] smp_v,
    output logic signed [DW-1:0] avg_i,
    output logic signed [DW-1:0] avg_v,
    output logic signed [DW-1:0] v_first,
    output logic signed [DW-1:0] v_last
);
    localparam int AW = DW + NW;

    logic [NW-1:0]        n;
    logic signed [AW-1:0] sum_i;
    logic signed [AW-1:0] sum_v;
    logic signed [AW-1:0] den;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            n       <= '0;
            sum_i   <= '0;
            sum_v   <= '0;
            v_first <= '0;
            v_last  <= '0;
        end else if (en && vld) begin
            n      <= n + 1'b1;
            sum_i  <= sum_i + AW'(smp_i);
            sum_v  <= sum_v + AW'(smp_v);
            v_last <= smp_v;
            if (n == '0)
                v_first <= smp_v;
        end
    end

    always_comb begin
        den   = $signed({{DW{1'b0}}, n});
        avg_i = (n == '0) ? '0 : DW'(sum_i / den);
        avg_v = (n == '0) ? '0 : DW'(sum_v / den);
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(n));

endmodule

// File: rtl/poe_det_judge.sv
module poe_det_judge
    import poe_det_pkg::*;
#(
    parameter int DW          = 16,
    parameter int V_POS_TH    = 12000,
    parameter int V_NEG_TH    = -12000,
    parameter int I_MIN_DIFF  = 10,
    parameter int R_ACC_LO    = 19000,
    parameter int R_ACC_HI    = 26500,
    parameter int RES_SCALE   = 1000,
    parameter int DRIFT_NORM  = 100,
    parameter int DRIFT_LARGE = 1000
) (
    input  logic                 cap_large,
    input  logic signed [DW-1:0] i_lo,
    input  logic signed [DW-1:0] v_lo,
    input  logic signed [DW-1:0] i_hi,
    input  logic signed [DW-1:0] v_hi,
    input  logic signed [DW-1:0] first_lo,
    input  logic signed [DW-1:0] last_lo,
    input  logic signed [DW-1:0] first_hi,
    input  logic signed [DW-1:0] last_hi,
    output det_res_e             res
);
    localparam int RW = 2 * DW + 16;
    localparam logic signed [DW-1:0] VPOS = DW'(V_POS_TH);
    localparam logic signed [DW-1:0] VNEG = DW'(V_NEG_TH);
    localparam logic signed [RW-1:0] IMIN = RW'(I_MIN_DIFF);
    localparam logic signed [RW-1:0] RLO  = RW'(R_ACC_LO);
    localparam logic signed [RW-1:0] RHI  = RW'(R_ACC_HI);
    localparam logic signed [RW-1:0] RSC  = RW'(RES_SCALE);
    localparam logic signed [RW-1:0] DNRM = RW'(DRIFT_NORM);
    localparam logic signed [RW-1:0] DLRG = RW'(DRIFT_LARGE);

    logic signed [RW-1:0] dv, di, di_abs, rq, d_lo, d_hi, dlim;

    always_comb begin
        dv     = RW'(v_hi) - RW'(v_lo);
        di     = RW'(i_hi) - RW'(i_lo);
        di_abs = di[RW-1] ? -di : di;
        d_lo   = RW'(last_lo) - RW'(first_lo);
        if (d_lo[RW-1]) d_lo = -d_lo;
        d_hi   = RW'(last_hi) - RW'(first_hi);
        if (d_hi[RW-1]) d_hi = -d_hi;
        dlim   = cap_large ? DLRG : DNRM;
        rq     = (di == '0) ? '0 : (dv * RSC) / di;

        if (v_lo >= VPOS && v_hi >= VPOS)
            res = RES_DC_POS;
        else if (v_lo <= VNEG && v_hi <= VNEG)
            res = RES_DC_NEG;
        else if (d_lo > dlim || d_hi > dlim)
            res = RES_HIGH_C;
        else if (di_abs <= IMIN)
            res = RES_OPEN;
        else if (rq < RLO)
            res = RES_LOW_R;
        else if (rq > RHI)
            res = RES_HIGH_R;
        else
            res = RES_VALID;
    end

endmodule

// File: rtl/poe_detect_seq.sv
module poe_detect_seq
    import poe_det_pkg::*;
#(
    parameter int DW          = 16,
    parameter int NW          = 16,
    parameter int SETTLE_MS   = 10,
    parameter int INTEG_MS    = 100,
    parameter int BACKOFF_MS  = 2200,
    parameter int V_POS_TH    = 12000,
    parameter int V_NEG_TH    = -12000,
    parameter int I_MIN_DIFF  = 10,
    parameter int R_ACC_LO    = 19000,
    parameter int R_ACC_HI    = 26500,
    parameter int RES_SCALE   = 1000,
    parameter int DRIFT_NORM  = 100,
    parameter int DRIFT_LARGE = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          det_cmd,
    input  logic          midspan_en,
    input  logic          big_cap_en,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_i,
    input  logic [DW-1:0] smp_v,
    output logic          probe_sel,
    output logic          gate_en,
    output logic          det_done,
    output logic [2:0]    det_result
);
    localparam int MAX_A  = (SETTLE_MS > INTEG_MS) ? SETTLE_MS : INTEG_MS;
    localparam int MAX_MS = (MAX_A > BACKOFF_MS) ? MAX_A : BACKOFF_MS;
    localparam int CW     = $clog2(MAX_MS + 1);

    det_st_e  state, nxt;
    det_res_e verdict, res_q;
    logic     mid_q, cap_q;
    logic     tmr_run, tmr_expire, acc_clr;
    logic [CW-1:0] tmr_limit;

    logic signed [DW-1:0] avg_i   [2];
    logic signed [DW-1:0] avg_v   [2];
    logic signed [DW-1:0] v_first [2];
    logic signed [DW-1:0] v_last  [2];

    // Timer phase and length follow the state
    always_comb begin
        tmr_run = (state == ST_SETTLE1) || (state == ST_INTEG1) ||
                  (state == ST_SETTLE2) || (state == ST_INTEG2) ||
                  (state == ST_BACKOFF);
        unique case (state)
            ST_SETTLE1, ST_SETTLE2: tmr_limit = CW'(SETTLE_MS);
            ST_INTEG1, ST_INTEG2:   tmr_limit = CW'(INTEG_MS);
            default:                tmr_limit = CW'(BACKOFF_MS);
        endcase
    end

    poe_det_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (det_cmd),
        .tick    (ms_tick),
        .limit   (tmr_limit),
        .expire  (tmr_expire)
    );

    assign acc_clr = det_cmd || ((state == ST_BACKOFF) && tmr_expire);

    // One accumulator per probe point
    for (genvar g = 0; g < 2; g++) begin : g_point
        localparam det_st_e INTEG_ST = (g == 0) ? ST_INTEG1 : ST_INTEG2;
        poe_det_accum #(.DW(DW), .NW(NW)) u_accum (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (acc_clr),
            .en      (state == INTEG_ST),
            .vld     (smp_vld),
            .smp_i   ($signed(smp_i)),
            .smp_v   ($signed(smp_v)),
            .avg_i   (avg_i[g]),
            .avg_v   (avg_v[g]),
            .v_first (v_first[g]),
            .v_last  (v_last[g])
        );
    end

    poe_det_judge #(
        .DW(DW), .V_POS_TH(V_POS_TH), .V_NEG_TH(V_NEG_TH),
        .I_MIN_DIFF(I_MIN_DIFF), .R_ACC_LO(R_ACC_LO), .R_ACC_HI(R_ACC_HI),
        .RES_SCALE(RES_SCALE), .DRIFT_NORM(DRIFT_NORM), .DRIFT_LARGE(DRIFT_LARGE)
    ) u_judge (
        .cap_large (cap_q),
        .i_lo      (avg_i[0]),
        .v_lo      (avg_v[0]),
        .i_hi      (avg_i[1]),
        .v_hi      (avg_v[1]),
        .first_lo  (v_first[0]),
        .last_lo   (v_last[0]),
        .first_hi  (v_first[1]),
        .last_hi   (v_last[1]),
        .res       (verdict)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        if (det_cmd)
            nxt = ST_SETTLE1;
        else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_SETTLE1: if (tmr_expire) nxt = ST_INTEG1;
                ST_INTEG1:  if (tmr_expire) nxt = ST_SETTLE2;
                ST_SETTLE2: if (tmr_expire) nxt = ST_INTEG2;
                ST_INTEG2:  if (tmr_expire) nxt = ST_VERDICT;
                ST_VERDICT: nxt = (verdict != RES_VALID && mid_q) ? ST_BACKOFF : ST_IDLE;
                ST_BACKOFF: if (tmr_expire) nxt = ST_SETTLE1;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // State register with mode capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            mid_q <= 1'b0;
            cap_q <= 1'b0;
        end else begin
            state <= nxt;
            if (det_cmd) begin
                mid_q <= midspan_en;
                cap_q <= big_cap_en;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_done <= 1'b0;
            res_q    <= RES_NONE;
        end else begin
            det_done <= (state == ST_VERDICT);
            if (state == ST_VERDICT)
                res_q <= verdict;
        end
    end

    assign det_result = res_q;
    assign probe_sel  = (state == ST_SETTLE2) || (state == ST_INTEG2);
    assign gate_en    = 1'b0;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |=> !det_done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !det_done |-> $stable(det_result));

    // R9
    verdict_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTEG2 && tmr_expire && !det_cmd) |=> ##1 det_done);

    // R2
    probe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_sel) |-> $past(state == ST_INTEG1));

    // R11
    backoff_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BACKOFF && det_cmd) |=> (state == ST_SETTLE1));

endmodule

// File: tb/poe_detect_seq_bench.sv
module poe_detect_seq_bench;
    localparam int DW = 16, SET = 3, INT = 4, BO = 6, TDIV = 4;

    logic clk = 0, rst_n = 0, ms_tick = 0, det_cmd = 0;
    logic midspan_en = 0, big_cap_en = 0, smp_vld = 0;
    logic [DW-1:0] smp_i = '0, smp_v = '0;
    logic probe_sel, gate_en, det_done;
    logic [2:0] det_result;

    int tests = 0, fails = 0, done_cnt = 0, cyc = 0;
    int scen = 0, kk = 0, tdiv = 0;
    bit alt = 0, finished = 0;

    poe_detect_seq #(
        .DW(DW), .NW(16), .SETTLE_MS(SET), .INTEG_MS(INT), .BACKOFF_MS(BO),
        .V_POS_TH(12000), .V_NEG_TH(-12000), .I_MIN_DIFF(10),
        .R_ACC_LO(19000), .R_ACC_HI(26500), .RES_SCALE(1000),
        .DRIFT_NORM(100), .DRIFT_LARGE(1000)
    ) u_poe_detect_seq (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp_v);
        tests++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Stimulus: tick and emulated load
    always @(negedge clk) begin
        int vb, ib;
        tdiv = (tdiv + 1) % TDIV;
        ms_tick = (tdiv == 0);
        alt = ~alt;
        if (probe_sel) kk++; else kk = 0;
        vb = probe_sel ? 8000 : 4000;
        ib = probe_sel ? 320 : 160;
        smp_vld = 1'b1;
        case (scen)
            1: ib = probe_sel ? 800 : 400;
            2: ib = probe_sel ? 200 : 100;
            3: ib = 0;
            4: begin vb = 15000; ib = 10; end
            5: begin vb = -15000; ib = -10; end
            6: if (probe_sel) vb = 7800 + 10 * kk;
            7: ib = ib + (alt ? 40 : -40);
            8: begin smp_vld = alt; if (!alt) begin vb = -20000; ib = 5000; end end
            default: ;
        endcase
        smp_i = DW'(ib);
        smp_v = DW'(vb);
    end

    // Reference model
    int m_st, m_cnt, m_res, mn[2], mvf[2], mvl[2];
    longint ms_i[2], ms_v[2];
    bit m_done, m_mid, m_cap;

    function automatic int judge(input bit cap);
        longint ai[2], av[2], dv, di, r, d[2], lim;
        for (int p = 0; p < 2; p++) begin
            ai[p] = (mn[p] == 0) ? 0 : ms_i[p] / mn[p];
            av[p] = (mn[p] == 0) ? 0 : ms_v[p] / mn[p];
            d[p]  = mvl[p] - mvf[p];
            if (d[p] < 0) d[p] = -d[p];
        end
        lim = cap ? 1000 : 100;
        dv = av[1] - av[0];
        di = ai[1] - ai[0];
        if (av[0] >= 12000 && av[1] >= 12000) return 5;
        if (av[0] <= -12000 && av[1] <= -12000) return 6;
        if (d[0] > lim || d[1] > lim) return 4;
        if ((di < 0 ? -di : di) <= 10) return 1;
        r = dv * 1000 / di;
        if (r < 19000) return 2;
        if (r > 26500) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit run, ex, start;
        int lim, nx, p;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_done = 0; m_res = 7; m_mid = 0; m_cap = 0;
            for (int q = 0; q < 2; q++) begin mn[q] = 0; ms_i[q] = 0; ms_v[q] = 0; mvf[q] = 0; mvl[q] = 0; end
        end else begin
            run = (m_st >= 1 && m_st <= 4) || m_st == 6;
            lim = (m_st == 1 || m_st == 3) ? SET : ((m_st == 2 || m_st == 4) ? INT : BO);
            ex = run && ms_tick && (m_cnt == lim - 1);
            start = det_cmd || (m_st == 6 && ex);
            m_done = (m_st == 5);
            if (m_st == 5) m_res = judge(m_cap);
            nx = m_st;
            case (m_st)
                1: if (ex) nx = 2;
                2: if (ex) nx = 3;
                3: if (ex) nx = 4;
                4: if (ex) nx = 5;
                5: nx = (m_res != 0 && m_mid) ? 6 : 0;
                6: if (ex) nx = 1;
                default: ;
            endcase
            if (start) begin
                for (int q = 0; q < 2; q++) begin mn[q] = 0; ms_i[q] = 0; ms_v[q] = 0; mvf[q] = 0; mvl[q] = 0; end
            end else if (smp_vld && (m_st == 2 || m_st == 4)) begin
                p = (m_st == 4) ? 1 : 0;
                if (mn[p] == 0) mvf[p] = $signed(smp_v);
                mvl[p] = $signed(smp_v);
                ms_i[p] += $signed(smp_i);
                ms_v[p] += $signed(smp_v);
                mn[p]++;
            end
            if (det_cmd) begin nx = 1; m_mid = midspan_en; m_cap = big_cap_en; end
            m_cnt = (det_cmd || !run || ex) ? 0 : m_cnt + (ms_tick ? 1 : 0);
            m_st = nx;
        end
    end

    // Per-clock comparison
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n && !finished) begin
            check("R1 gate_en", gate_en, 0);
            check("R2 probe_sel", probe_sel, (m_st == 3 || m_st == 4) ? 1 : 0);
            check("R9 det_done", det_done, m_done);
            check("R4 det_result", det_result, m_res);
            if (det_done) done_cnt++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    int lat;

    task automatic wait_done();
        int c0 = done_cnt;
        lat = 0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); #3;
            lat++;
            if (done_cnt > c0) break;
        end
    endtask

    task automatic pulse_cmd(input bit mid, input bit cap);
        @(negedge clk);
        midspan_en = mid; big_cap_en = cap; det_cmd = 1;
        @(negedge clk);
        det_cmd = 0;
    endtask

    task automatic run_one(input int sc, input bit cap, input int exp_v, input string tag);
        scen = sc;
        pulse_cmd(0, cap);
        wait_done();
        check(tag, det_result, exp_v);
        repeat (5) @(negedge clk);
    endtask

    int base_lat, dc0;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #3;
        check("R4 reset result", det_result, 7);
        check("R9 reset done", det_done, 0);
        check("R2 reset probe", probe_sel, 0);
        // R12: idle ignores ticks and samples
        dc0 = done_cnt;
        repeat (40) @(negedge clk);
        check("R12 idle no done", done_cnt, dc0);
        check("R12 idle result", det_result, 7);

        run_one(0, 0, 0, "R8 valid 25k");
        base_lat = lat;
        run_one(1, 0, 2, "R8 low resistance");
        run_one(2, 0, 3, "R8 high resistance");
        run_one(3, 0, 1, "R7 open circuit");
        run_one(4, 0, 5, "R5 positive DC");
        run_one(5, 0, 6, "R5 negative DC");
        run_one(6, 0, 4, "R6 high capacitance");
        run_one(6, 1, 0, "R6 large cap enabled");
        run_one(7, 0, 0, "R3 noisy current averaged");
        run_one(8, 0, 0, "R3 invalid samples ignored");

        // R10: no retry without midspan
        dc0 = done_cnt;
        repeat (150) @(negedge clk);
        check("R10 no retry", done_cnt, dc0);

        // R10/R11: midspan retry, mode captured at command
        scen = 3;
        pulse_cmd(1, 0);
        midspan_en = 0;
        wait_done();
        check("R7 midspan open", det_result, 1);
        scen = 0;
        wait_done();
        check("R10 retry valid", det_result, 0);
        check("R10 backoff waited", (lat > BO * TDIV) ? 1 : 0, 1);
        dc0 = done_cnt;
        repeat (150) @(negedge clk);
        check("R10 valid ends retry", done_cnt, dc0);

        // R11: command aborts backoff
        scen = 3;
        pulse_cmd(1, 0);
        wait_done();
        check("R11 open before abort", det_result, 1);
        repeat (3) @(negedge clk);
        scen = 0;
        pulse_cmd(1, 0);
        wait_done();
        check("R11 abort valid", det_result, 0);
        check("R11 abort latency", (lat <= base_lat + TDIV) ? 1 : 0, 1);

        // R11: command in verdict cycle
        scen = 0;
        dc0 = done_cnt;
        pulse_cmd(0, 0);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (m_st == 5) break;
        end
        det_cmd = 1;
        @(negedge clk);
        det_cmd = 0;
        wait_done();
        check("R11 verdict plus restart", done_cnt, dc0 + 2);
        check("R11 restart result", det_result, 0);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule